// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block is the interrupt logic of a peripheral that has two serial channels and a small built-in DMA engine. Each serial channel raises three kinds of event (receive, transmit, line status), and each DMA channel raises one. Every source has a pending bit, an under-service bit and an enable bit. The serial cell and the DMA cell each have a master enable. Sources are arbitrated in a fixed priority order inside the block. The block also takes part in a system priority chain through an enable input (`iei`) and an enable output (`ieo`).

The block drives an active-low request, `int_n`. When the processor acknowledges, the block returns an 8-bit vector taken from the base of the cell that wins. The vector is either the base as written or the base with the winning source encoded into bits [3:1]. The same acknowledge marks the winner as under service. That blocks every lower-priority source, both inside the block and downstream on the chain, until software writes the release register. Software can also poll the pending registers instead of using interrupts.

Top module: `irq_chain_ctl`

## Requirements
- R1: There are 6+NUM_DMA sources with fixed priority, where a lower index means higher priority. Sources 0..5 are `ser_evt` bits 0..5: channel A receive, A transmit, A status, then B receive, B transmit, B status. Source 6+j is `dma_evt` bit j. At most one source is granted at a time, and the grant always goes to the highest-priority eligible source.
- R2: A source is eligible only when all of the following hold: its pending bit is set, its enable bit is set, and its cell's master enable is set. The master enables are in register 2: bit 0 for the serial cell and bit 1 for the DMA cell.
- R3: A serial pending bit is set by its event only if its enable bit is set in the same cycle. A DMA pending bit is set by its event whatever its enable bit holds.
- R4: Serial enables are written at address 0 (bits 5:0), and a read of address 0 returns zero. DMA enables are at address 1 (bits NUM_DMA-1:0) and can be both written and read back.
- R5: `int_n` is low only while some eligible source is reachable along the chain, and `iei` is high.
- R6: While any under-service bit is set, every lower-priority source is blocked and `ieo` is low.
- R7: `ieo` equals `iei` when no under-service bit is set and no source is eligible. In every other case `ieo` is low, and `iei` low always forces `ieo` low.
- R8: During a cycle with `iack` high and a request present, `vec_valid` is 1 and `vec_out` carries the vector. At the next clock edge the winner's under-service bit is set. The under-service bits read back at address 7.
- R9: The serial vector base is at address 3 and the DMA vector base is at address 4. Register 2 bit 2 enables cause encoding for the serial cell: bits [3:1] of the vector become the source index 0..5. Register 2 bit 3 does the same for the DMA cell, with the DMA channel index. With encoding off, the base is returned unchanged.
- R10: Address 5 reads the pending bits of both serial channels in bits [5:0], and address 6 reads the DMA pending bits. Writing ones to either address clears those bits. An event in the same cycle as the clear wins.
- R11: A write of any value to address 7 clears the highest-priority under-service bit that was set before the edge. An acknowledge in the same cycle still sets its own winner's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_evt | input | 6 | Serial source event pulses |
| dma_evt | input | NUM_DMA | DMA channel event pulses |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| iei | input | 1 | Chain enable from higher-priority devices |
| ieo | output | 1 | Chain enable to lower-priority devices |
| int_n | output | 1 | Active-low interrupt request |
| iack | input | 1 | Interrupt acknowledge, one cycle |
| vec_out | output | 8 | Vector returned during acknowledge |
| vec_valid | output | 1 | Vector is driven this cycle |

## Verification
An acknowledge and a release write to address 7 can fall in the same cycle. This is provoked by leaving a lower source under service, raising a higher-priority source, and then asserting `iack` together with the release write. The bench judges the result by reading the under-service register afterward. It must hold only the new winner, which shows that the old bit was cleared using the state from before the edge. The bench also drives an event and a write-one-to-clear of the same pending bit together, and expects the bit to survive.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    localparam int SER_SRC = 6;
    localparam int VEC_W   = 8;

    typedef enum logic [2:0] {
        RA_SER_IE  = 3'd0,
        RA_DMA_IE  = 3'd1,
        RA_CTRL    = 3'd2,
        RA_SER_VEC = 3'd3,
        RA_DMA_VEC = 3'd4,
        RA_SER_IP  = 3'd5,
        RA_DMA_IP  = 3'd6,
        RA_IUS     = 3'd7
    } reg_addr_e;

    // Control register. The last field is bit 0.
    typedef struct packed {
        logic dma_vis;
        logic ser_vis;
        logic dma_mie;
        logic ser_mie;
    } ctrl_t;

    function automatic logic [VEC_W-1:0] apply_status(input logic [VEC_W-1:0] base,
                                                      input logic en,
                                                      input logic [2:0] code);
        return en ? {base[VEC_W-1:4], code, base[0]} : base;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N    = 6,
    parameter bit GATE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] ie,
    input  logic [N-1:0] clr,
    output logic [N-1:0] ip
);
    logic [N-1:0] set_v;

    generate
        if (GATE) begin : g_gated
            assign set_v = evt & ie;
        end else begin : g_free
            assign set_v = evt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ip <= '0;
        else     ip <= (ip & ~clr) | set_v;
    end
endmodule

// File: rtl/irq_daisy.sv
module irq_daisy #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  elig,
    input  logic [N-1:0]  ius,
    input  logic          iei,
    output logic [N-1:0]  req,
    output logic          ieo,
    output logic [IW-1:0] win,
    output logic          win_ok
);
    logic en;

    always_comb begin
        en     = iei;
        req    = '0;
        win    = '0;
        win_ok = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (en && elig[i] && !ius[i]) begin
                req[i] = 1'b1;
                win    = IW'(i);
                win_ok = 1'b1;
            end
            en = en && !ius[i] && !elig[i];
        end
        ieo = en;
    end
endmodule

// File: rtl/irq_ius_track.sv
module irq_ius_track #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_hi,
    output logic [N-1:0]  ius
);
    logic [N-1:0] hi_mask;
    logic         found;

    always_comb begin
        hi_mask = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ius[i] && !found) begin
                hi_mask[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ius <= '0;
        else     ius <= (ius & ~(clr_hi ? hi_mask : '0))
                        | (set_en ? (N'(1) << set_idx) : '0);
    end
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
    import irq_chain_pkg::*;
#(
    parameter int NUM_DMA = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         ser_evt,
    input  logic [NUM_DMA-1:0] dma_evt,
    input  logic               wr_en,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    input  logic               iei,
    output logic               ieo,
    output logic               int_n,
    input  logic               iack,
    output logic [7:0]         vec_out,
    output logic               vec_valid
);
    localparam int NSRC = SER_SRC + NUM_DMA;
    localparam int IW   = $clog2(NSRC);

    reg_addr_e          sel;
    ctrl_t              ctrl;
    logic [5:0]         ser_ie, ser_ip, ser_clr;
    logic [NUM_DMA-1:0] dma_ie, dma_ip, dma_clr;
    logic [7:0]         ser_base, dma_base, vec_c;
    logic [NSRC-1:0]    elig, req, ius;
    logic [IW-1:0]      win;
    logic               win_ok, ser_mie, dma_mie;

    assign sel     = reg_addr_e'(reg_addr);
    assign ser_mie = ctrl.ser_mie;
    assign dma_mie = ctrl.dma_mie;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_ie   <= '0;
            dma_ie   <= '0;
            ctrl     <= '0;
            ser_base <= '0;
            dma_base <= '0;
        end else if (wr_en) begin
            case (sel)
                RA_SER_IE:  ser_ie   <= wr_data[5:0];
                RA_DMA_IE:  dma_ie   <= wr_data[NUM_DMA-1:0];
                RA_CTRL:    ctrl     <= ctrl_t'(wr_data[3:0]);
                RA_SER_VEC: ser_base <= wr_data;
                RA_DMA_VEC: dma_base <= wr_data;
                default: ;
            endcase
        end
    end

    assign ser_clr = (wr_en && sel == RA_SER_IP) ? wr_data[5:0] : '0;
    assign dma_clr = (wr_en && sel == RA_DMA_IP) ? wr_data[NUM_DMA-1:0] : '0;

    irq_pend_bank #(.N(SER_SRC), .GATE(1'b1)) u_ser_pend (
        .clk(clk), .rst(rst), .evt(ser_evt), .ie(ser_ie), .clr(ser_clr), .ip(ser_ip));

    irq_pend_bank #(.N(NUM_DMA), .GATE(1'b0)) u_dma_pend (
        .clk(clk), .rst(rst), .evt(dma_evt), .ie(dma_ie), .clr(dma_clr), .ip(dma_ip));

    assign elig = {dma_ip & dma_ie & {NUM_DMA{dma_mie}},
                   ser_ip & ser_ie & {SER_SRC{ser_mie}}};

    irq_daisy #(.N(NSRC), .IW(IW)) u_daisy (
        .elig(elig), .ius(ius), .iei(iei), .req(req), .ieo(ieo),
        .win(win), .win_ok(win_ok));

    irq_ius_track #(.N(NSRC), .IW(IW)) u_ius (
        .clk(clk), .rst(rst), .set_en(iack && win_ok), .set_idx(win),
        .clr_hi(wr_en && sel == RA_IUS), .ius(ius));

    assign int_n = ~|req;

    always_comb begin
        if (win < IW'(SER_SRC))
            vec_c = apply_status(ser_base, ctrl.ser_vis, 3'(win));
        else
            vec_c = apply_status(dma_base, ctrl.dma_vis, 3'(win - IW'(SER_SRC)));
    end

    assign vec_valid = iack && win_ok;
    assign vec_out   = vec_valid ? vec_c : '0;

    always_comb begin
        case (sel)
            RA_SER_IE:  rd_data = '0;
            RA_DMA_IE:  rd_data = 8'(dma_ie);
            RA_CTRL:    rd_data = {4'b0, ctrl};
            RA_SER_VEC: rd_data = ser_base;
            RA_DMA_VEC: rd_data = dma_base;
            RA_SER_IP:  rd_data = {2'b0, ser_ip};
            RA_DMA_IP:  rd_data = 8'(dma_ip);
            default:    rd_data = 8'(ius);
        endcase
    end
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int NUM_DMA = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 iei,
    input logic                 ieo,
    input logic                 int_n,
    input logic                 iack,
    input logic                 vec_valid,
    input logic                 ser_mie,
    input logic                 dma_mie,
    input logic [5:0]           ser_ie,
    input logic [5:0]           ser_ip,
    input logic [6+NUM_DMA-1:0] ius,
    input logic [6+NUM_DMA-1:0] req
);
    for (genvar i = 0; i < 6; i++) begin : g_ser
        AST_SER_IP_GATED: assert property (@(posedge clk) disable iff (rst)
            $rose(ser_ip[i]) |-> $past(ser_ie[i])); // R3
    end

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req)); // R1
    AST_MASTER_GATES: assert property (@(posedge clk) disable iff (rst)
        (!ser_mie && !dma_mie) |-> int_n); // R2
    AST_REQ_NEEDS_IEI: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> iei); // R5
    AST_IUS_HOLDS_IEO: assert property (@(posedge clk) disable iff (rst)
        (|ius) |-> !ieo); // R6
    AST_IEI_LOW_IEO: assert property (@(posedge clk) disable iff (rst)
        !iei |-> !ieo); // R7
    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (rst)
        (iack && vec_valid) |=> (|ius)); // R8
endmodule

bind irq_chain_ctl irq_chain_chk #(.NUM_DMA(NUM_DMA)) u_chk (
    .clk(clk), .rst(rst), .iei(iei), .ieo(ieo), .int_n(int_n), .iack(iack),
    .vec_valid(vec_valid), .ser_mie(ser_mie), .dma_mie(dma_mie),
    .ser_ie(ser_ie), .ser_ip(ser_ip), .ius(ius), .req(req));

// File: tb/test_irq_chain_ctl.sv
module test_irq_chain_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    ser_evt = '0;
    logic [ND-1:0] dma_evt = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          iei = 1'b1;
    logic          ieo, int_n, iack = 1'b0, vec_valid;
    logic [7:0]    vec_out;
    int            n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_chain_ctl #(.NUM_DMA(ND)) i_irq_chain_ctl (
        .clk(clk), .rst(rst), .ser_evt(ser_evt), .dma_evt(dma_evt),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .iei(iei), .ieo(ieo), .int_n(int_n), .iack(iack),
        .vec_out(vec_out), .vec_valid(vec_valid));

    typedef struct packed {
        logic [5:0] sev;
        logic [1:0] dev;
        logic [3:0] ctl;
        logic       iei_v;
        logic       eint;
        logic       eieo;
        logic [7:0] evec;
    } row_t;

    // Control field: bit0 serial master, bit1 DMA master, bit2 serial cause, bit3 DMA cause.
    // Serial base A0, DMA base 50.
    localparam row_t TBL [12] = '{
        '{6'b000001, 2'b00, 4'b0111, 1'b1, 1'b0, 1'b0, 8'hA0},
        '{6'b100100, 2'b00, 4'b0111, 1'b1, 1'b0, 1'b0, 8'hA4},
        '{6'b110000, 2'b00, 4'b0111, 1'b1, 1'b0, 1'b0, 8'hA8},
        '{6'b000000, 2'b10, 4'b1111, 1'b1, 1'b0, 1'b0, 8'h52},
        '{6'b100000, 2'b01, 4'b1111, 1'b1, 1'b0, 1'b0, 8'hAA},
        '{6'b001000, 2'b00, 4'b0011, 1'b1, 1'b0, 1'b0, 8'hA0},
        '{6'b000000, 2'b01, 4'b0011, 1'b1, 1'b0, 1'b0, 8'h50},
        '{6'b000001, 2'b00, 4'b0111, 1'b0, 1'b1, 1'b0, 8'h00},
        '{6'b000010, 2'b00, 4'b0110, 1'b1, 1'b1, 1'b1, 8'h00},
        '{6'b000000, 2'b01, 4'b0101, 1'b1, 1'b1, 1'b1, 8'h00},
        '{6'b000000, 2'b00, 4'b0111, 1'b1, 1'b1, 1'b1, 8'h00},
        '{6'b111111, 2'b11, 4'b1111, 1'b1, 1'b0, 1'b0, 8'hA0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_addr = a;
        #1;
    endtask

    task automatic pulse(input logic [5:0] s, input logic [ND-1:0] d);
        @(negedge clk);
        ser_evt = s; dma_evt = d;
        @(negedge clk);
        ser_evt = '0; dma_evt = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R5 reset int_n", int_n, 1);
        chk("R7 reset ieo", ieo, 1);
        rd(3'd2); chk("R2 reset ctrl", rd_data, 0);
        rd(3'd5); chk("R10 reset ser ip", rd_data, 0);

        // R4 enable readback
        wr(3'd0, 8'h3F); rd(3'd0); chk("R4 ser ie reads zero", rd_data, 0);
        wr(3'd1, 8'h03); rd(3'd1); chk("R4 dma ie readback", rd_data, 8'h03);
        wr(3'd3, 8'hA0);
        wr(3'd4, 8'h50);

        // table walk: R1 R2 R5 R7 R8 R9
        foreach (TBL[k]) begin
            wr(3'd5, 8'h3F);
            wr(3'd6, 8'hFF);
            wr(3'd2, {4'b0, TBL[k].ctl});
            iei = TBL[k].iei_v;
            pulse(TBL[k].sev, TBL[k].dev);
            #1;
            chk($sformatf("R5 row%0d int_n", k), int_n, TBL[k].eint);
            chk($sformatf("R7 row%0d ieo", k), ieo, TBL[k].eieo);
            if (!TBL[k].eint) begin
                iack = 1'b1; #1;
                chk($sformatf("R9 row%0d vector", k), vec_out, TBL[k].evec);
                chk($sformatf("R8 row%0d vec_valid", k), vec_valid, 1);
                iack = 1'b0;
            end
            iei = 1'b1;
        end

        // R3 gating split between cells
        do_reset();
        wr(3'd2, 8'h03);
        pulse(6'b000010, 2'b01);
        rd(3'd5); chk("R3 serial ip gated by ie", rd_data, 0);
        rd(3'd6); chk("R3 dma ip latches without ie", rd_data, 8'h01);
        chk("R2 no request without ie", int_n, 1);

        // R10 poll, clear, event beats clear
        wr(3'd0, 8'h3F);
        pulse(6'b001000, 2'b00);
        rd(3'd5); chk("R10 poll ser ip", rd_data, 8'h08);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 3'd5; wr_data = 8'h08; ser_evt = 6'b001000;
        @(negedge clk);
        wr_en = 1'b0; ser_evt = '0;
        rd(3'd5); chk("R10 event wins over clear", rd_data, 8'h08);
        wr(3'd5, 8'h08);
        rd(3'd5); chk("R10 clear", rd_data, 0);
        wr(3'd6, 8'h01);

        // R6 R8 R11 nesting
        wr(3'd3, 8'hA0);
        wr(3'd2, 8'h07);
        pulse(6'b010010, 2'b00);
        #1; chk("R1 vector of highest", int_n, 0);
        @(negedge clk);
        iack = 1'b1; #1;
        chk("R9 ack vector A tx", vec_out, 8'hA2);
        @(negedge clk);
        iack = 1'b0;
        rd(3'd7); chk("R8 ius set by ack", rd_data, 8'h02);
        chk("R6 lower blocked", int_n, 1);
        chk("R6 ieo low under service", ieo, 0);
        pulse(6'b000001, 2'b00);
        #1; chk("R6 higher still requests", int_n, 0);
        @(negedge clk);
        iack = 1'b1; wr_en = 1'b1; reg_addr = 3'd7; wr_data = 8'h00; #1;
        chk("R9 nested vector", vec_out, 8'hA0);
        @(negedge clk);
        iack = 1'b0; wr_en = 1'b0;
        rd(3'd7); chk("R11 ack with release same cycle", rd_data, 8'h01);
        wr(3'd5, 8'h01);
        wr(3'd7, 8'h00);
        rd(3'd7); chk("R11 release", rd_data, 0);
        chk("R1 pending resumes", int_n, 0);
        chk("R7 ieo low while pending", ieo, 0);
        wr(3'd5, 8'h3F);
        #1; chk("R7 ieo follows iei", ieo, 1);
        iei = 1'b0; #1;
        chk("R7 iei low forces ieo", ieo, 0);
        iei = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule